// File: doc/BRIEF.md
# Floating-Point Multiply Special-Operand Resolver

This block sits at the front of a 64-bit binary floating-point multiplier. For each operand pair it decides whether the product is already fixed by the class of the operands (not-a-number, infinity or zero). When it is, the block delivers the finished 64-bit result, marks the item as bypassed, and raises either an invalid-flag request or, when invalid trapping is enabled, a trap request. When both operands are finite and nonzero it clears the bypass flag, so the mantissa datapath that follows computes the product. The product sign, the XOR of the operand signs, is produced for every pair.

Operand pairs enter on a valid/ready stream and leave one cycle later on a second valid/ready stream. The block holds one item. A pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output stays frozen and no new pair is taken. The invalid-trap enable is sampled together with the operands.

The operands are checked in a fixed order. The first operand is checked for not-a-number or infinity first, then the second operand is checked for the same. Zero is looked at only after both. As a result, zero times NaN returns the NaN, and a signaling NaN in the second operand wins over a quiet NaN in the first.

Top module: `fmul_special_resolve`

## Requirements
- R1: A pair is taken on a rising edge with `in_valid` and `in_ready` both high, and its result is presented with `out_valid` from the next cycle on. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs hold their values.
- R2: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R3: `out_sign` equals bit 63 of operand A XOR bit 63 of operand B for every pair. Signed infinity and signed zero results carry this sign in bit 63.
- R4: If A is a NaN, the block bypasses. If A is signaling, it returns A quieted with invalid. Otherwise, if B is signaling, it returns B quieted with invalid. Otherwise it returns A unchanged.
- R5: If A is not a NaN and B is a NaN, the block bypasses and returns B, quieted and with invalid if B was signaling. This applies even when A is infinity or zero.
- R6: Infinity times zero, in either order, is invalid. With trapping disabled, the result is the default quiet NaN 0x7FF8000000000000 and `out_set_invalid` is 1.
- R7: When a case is invalid and `in_trap_en` was 1, the block gives `out_trap`=1, `out_set_invalid`=0, `out_bypass`=1 and `out_result`=0.
- R8: Infinity times a nonzero value that is not a NaN (subnormal, normal or infinity) returns infinity (exponent all ones, mantissa 0) with the R3 sign.
- R9: Zero times a finite value (zero, subnormal or normal) returns zero with the R3 sign and no flags.
- R10: When both operands are finite and nonzero, `out_bypass`, `out_set_invalid` and `out_trap` are 0 and `out_result` is 0.
- R11: Classes are decoded from the fields. Bit 63 is the sign, bits 62:52 the exponent and bits 51:0 the mantissa. An all-ones exponent with a zero mantissa is infinity. An all-ones exponent with a nonzero mantissa is a NaN, signaling when mantissa bit 51 is 0. Quieting sets bit 51 and keeps the sign and all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_op_a | input | 64 | First operand (IEEE double) |
| in_op_b | input | 64 | Second operand (IEEE double) |
| in_trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Final product when bypassed, else 0 |
| out_sign | output | 1 | Product sign |
| out_bypass | output | 1 | Product fixed by operand class |
| out_set_invalid | output | 1 | Request to set the invalid flag |
| out_trap | output | 1 | Invalid-operation trap request |

## Verification
A wrong internal decision is visible at the ports on the first cycle the item is presented. Some examples:
- A misplaced check order returns the wrong NaN payload or the wrong quiet bit.
- A lost trap gating shows both flags at once, or a nonzero result next to a trap.
- A broken hold register changes the payload while the consumer stalls, in the very next cycle.

Every operand class pair is therefore driven with both trap settings under random back-pressure. Each presented item is compared field by field with an expected value computed from the class rules.

// File: rtl/fmul_sr_pkg.sv
package fmul_sr_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } opclass_e;

  function automatic logic cls_is_nan(opclass_e c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction

  function automatic logic cls_is_finite_nonzero(opclass_e c);
    return (c == CLS_SUB) || (c == CLS_NORM);
  endfunction

endpackage

// File: rtl/fmul_opclass.sv
module fmul_opclass
  import fmul_sr_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] op,
  output opclass_e             cls
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones, exp_zero, man_zero;

  assign exp_f    = op[W-2 -: EXP_W];
  assign man_f    = op[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_zero = ~|man_f;

  always_comb begin
    if (exp_ones) begin
      if (man_zero)             cls = CLS_INF;
      else if (man_f[MAN_W-1])  cls = CLS_QNAN;
      else                      cls = CLS_SNAN;
    end else if (exp_zero) begin
      cls = man_zero ? CLS_ZERO : CLS_SUB;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/fmul_special_decide.sv
module fmul_special_decide
  import fmul_sr_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  input  opclass_e             cls_a,
  input  opclass_e             cls_b,
  input  logic                 trap_en,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 sign,
  output logic                 bypass,
  output logic                 set_invalid,
  output logic                 trap
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] DEF_QNAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0] quiet_a, quiet_b, signed_inf, signed_zero, raw_res;
  logic         invalid;

  assign sign        = op_a[W-1] ^ op_b[W-1];
  assign quiet_a     = op_a | QUIET_BIT;
  assign quiet_b     = op_b | QUIET_BIT;
  assign signed_inf  = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  assign signed_zero = {sign, {(W-1){1'b0}}};

  always_comb begin
    raw_res = '0;
    bypass  = 1'b0;
    invalid = 1'b0;
    if (cls_is_nan(cls_a)) begin
      bypass = 1'b1;
      if (cls_a == CLS_SNAN) begin
        invalid = 1'b1;
        raw_res = quiet_a;
      end else if (cls_b == CLS_SNAN) begin
        invalid = 1'b1;
        raw_res = quiet_b;
      end else begin
        raw_res = op_a;
      end
    end else if (cls_a == CLS_INF) begin
      bypass = 1'b1;
      if (cls_is_nan(cls_b)) begin
        invalid = (cls_b == CLS_SNAN);
        raw_res = quiet_b;
      end else if (cls_b == CLS_ZERO) begin
        invalid = 1'b1;
        raw_res = DEF_QNAN;
      end else begin
        raw_res = signed_inf;
      end
    end else if (cls_is_nan(cls_b)) begin
      bypass  = 1'b1;
      invalid = (cls_b == CLS_SNAN);
      raw_res = quiet_b;
    end else if (cls_b == CLS_INF) begin
      bypass = 1'b1;
      if (cls_a == CLS_ZERO) begin
        invalid = 1'b1;
        raw_res = DEF_QNAN;
      end else begin
        raw_res = signed_inf;
      end
    end else if ((cls_a == CLS_ZERO) || (cls_b == CLS_ZERO)) begin
      bypass  = 1'b1;
      raw_res = signed_zero;
    end
  end

  always_comb begin
    trap        = invalid & trap_en;
    set_invalid = invalid & ~trap_en;
    result      = trap ? '0 : raw_res;
  end
endmodule

// File: rtl/fmul_stage_reg.sv
module fmul_stage_reg #(
  parameter int PW = 68
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [PW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [PW-1:0] dn_data
);
  logic          vld_q;
  logic [PW-1:0] data_q;

  assign up_ready = ~vld_q | dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end
endmodule

// File: rtl/fmul_special_resolve.sv
module fmul_special_resolve
  import fmul_sr_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [EXP_W+MAN_W:0] in_op_a,
  input  logic [EXP_W+MAN_W:0] in_op_b,
  input  logic                 in_trap_en,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [EXP_W+MAN_W:0] out_result,
  output logic                 out_sign,
  output logic                 out_bypass,
  output logic                 out_set_invalid,
  output logic                 out_trap
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int NF = 4;
  localparam int PW = W + NF;

  logic [1:0][W-1:0] ops;
  opclass_e          cls [2];

  assign ops[0] = in_op_a;
  assign ops[1] = in_op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fmul_opclass #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (ops[gi]),
      .cls (cls[gi])
    );
  end

  logic [W-1:0] d_result;
  logic         d_sign, d_bypass, d_inv, d_trap;

  fmul_special_decide #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
    .op_a        (in_op_a),
    .op_b        (in_op_b),
    .cls_a       (cls[0]),
    .cls_b       (cls[1]),
    .trap_en     (in_trap_en),
    .result      (d_result),
    .sign        (d_sign),
    .bypass      (d_bypass),
    .set_invalid (d_inv),
    .trap        (d_trap)
  );

  logic [PW-1:0] pl_in, pl_out;
  assign pl_in = {d_result, d_sign, d_bypass, d_inv, d_trap};

  fmul_stage_reg #(.PW(PW)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pl_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pl_out)
  );

  assign {out_result, out_sign, out_bypass, out_set_invalid, out_trap} = pl_out;
endmodule

module fmul_special_resolve_chk #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [EXP_W+MAN_W:0] out_result,
  input logic                 out_sign,
  input logic                 out_bypass,
  input logic                 out_set_invalid,
  input logic                 out_trap
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic res_exp_ones;
  assign res_exp_ones = &out_result[W-2 -: EXP_W];

  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_sign)
      && $stable(out_bypass) && $stable(out_set_invalid) && $stable(out_trap)));

  assert_stall_blocks_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_sign_on_result_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bypass && !res_exp_ones && !out_trap) |-> (out_result[W-1] == out_sign));

  assert_invalid_quiet_nan_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_set_invalid) |-> (out_bypass && res_exp_ones && out_result[MAN_W-1] && !out_trap));

  assert_trap_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_trap) |-> (out_bypass && !out_set_invalid && (out_result == '0)));

  assert_no_bypass_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_bypass) |-> (!out_set_invalid && !out_trap && (out_result == '0)));
endmodule

bind fmul_special_resolve fmul_special_resolve_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_sign(out_sign), .out_bypass(out_bypass),
  .out_set_invalid(out_set_invalid), .out_trap(out_trap)
);

// File: tb/fmul_special_resolve_tb_top.sv
module fmul_special_resolve_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic        in_ready;
  logic [63:0] in_op_a = '0, in_op_b = '0;
  logic        in_trap_en = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [63:0] out_result;
  logic        out_sign, out_bypass, out_set_invalid, out_trap;

  always #2 clk = ~clk;

  fmul_special_resolve dut_i (.*);

  typedef struct {
    logic [63:0] res;
    logic        sign, byp, inv, trp;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, failures = 0;
  bit   driving_done = 0;
  bit   stall_mode = 0;

  function automatic exp_t ref_mul(logic [63:0] a, logic [63:0] b, logic te);
    exp_t e;
    bit a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, a_sn, b_sn, bad;
    logic [63:0] qa, qb;
    a_nan  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    b_nan  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    a_inf  = (a[62:52] == 11'h7FF) && (a[51:0] == 0);
    b_inf  = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
    a_zero = (a[62:0] == 0);
    b_zero = (b[62:0] == 0);
    a_sn   = a_nan && !a[51];
    b_sn   = b_nan && !b[51];
    qa = a; qa[51] = 1'b1;
    qb = b; qb[51] = 1'b1;
    e.sign = a[63] ^ b[63];
    e.byp = 1; bad = 0; e.res = '0;
    if (a_nan) begin
      e.tag = "R4/R11";
      if (a_sn) begin bad = 1; e.res = qa; end
      else if (b_sn) begin bad = 1; e.res = qb; end
      else e.res = a;
    end else if (b_nan) begin
      e.tag = "R5/R11"; bad = b_sn; e.res = qb;
    end else if ((a_inf && b_zero) || (b_inf && a_zero)) begin
      e.tag = "R6"; bad = 1; e.res = 64'h7FF8000000000000;
    end else if (a_inf || b_inf) begin
      e.tag = "R8"; e.res = {e.sign, 11'h7FF, 52'h0};
    end else if (a_zero || b_zero) begin
      e.tag = "R9"; e.res = {e.sign, 63'h0};
    end else begin
      e.tag = "R10"; e.byp = 0;
    end
    e.inv = bad && !te;
    e.trp = bad && te;
    if (e.trp) begin e.res = '0; e.tag = {e.tag, "/R7"}; end
    return e;
  endfunction

  task automatic send(logic [63:0] a, logic [63:0] b, logic te);
    @(negedge clk);
    in_valid = 1; in_op_a = a; in_op_b = b; in_trap_en = te;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    exp_q.push_back(ref_mul(a, b, te));
  endtask

  // out_ready pattern: LFSR-driven stalls when stall_mode is set
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  // monitor
  logic        held = 0;
  logic [67:0] held_pl;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && held) begin
        checks++;
        if (!out_valid || {out_result, out_sign, out_bypass, out_set_invalid, out_trap} != held_pl) begin
          failures++;
          $display("FAIL R1 hold: act=%h/%b exp=%h/1", {out_result, out_sign, out_bypass, out_set_invalid, out_trap}, out_valid, held_pl);
        end
      end
      held = 0;
      if (!rst && out_valid && !out_ready) begin
        held = 1;
        held_pl = {out_result, out_sign, out_bypass, out_set_invalid, out_trap};
        checks++;
        if (in_ready) begin
          failures++;
          $display("FAIL R1 in_ready under stall: act=1 exp=0");
        end
      end
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R1 unexpected output: act=%h exp=none", out_result);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          if (out_sign !== e.sign) begin
            failures++;
            $display("FAIL R3 sign: act=%b exp=%b", out_sign, e.sign);
          end
          checks++;
          if (out_result !== e.res || out_bypass !== e.byp || out_set_invalid !== e.inv || out_trap !== e.trp) begin
            failures++;
            $display("FAIL %s: act=%h byp%b inv%b trp%b exp=%h byp%b inv%b trp%b", e.tag,
                     out_result, out_bypass, out_set_invalid, out_trap, e.res, e.byp, e.inv, e.trp);
          end
        end
      end
    end
  end

  logic [63:0] vals [10];
  initial begin
    vals[0] = 64'h0000000000000000; // +0
    vals[1] = 64'h8000000000000000; // -0
    vals[2] = 64'h0000000000000001; // +subnormal
    vals[3] = 64'h800F000000000000; // -subnormal
    vals[4] = 64'h3FF0000000000000; // +1.0
    vals[5] = 64'hC008000000000000; // -3.0
    vals[6] = 64'h7FF0000000000000; // +inf
    vals[7] = 64'hFFF0000000000000; // -inf
    vals[8] = 64'h7FFC000000000ABC; // quiet NaN
    vals[9] = 64'hFFF0000000000DEF; // signaling NaN
  end

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R2 during reset: act=v%b r%b exp=v0 r1", out_valid, in_ready);
    end
    @(negedge clk); rst = 0;
    @(negedge clk); #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R2 after reset: act=v%b r%b exp=v0 r1", out_valid, in_ready);
    end
    // all class pairs, both trap settings, first without then with back-pressure
    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++)
            send(vals[i], vals[j], t[0]);
    end
    @(negedge clk); in_valid = 0;
    repeat (50) @(negedge clk);
    stall_mode = 0;
    repeat (10) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R1 results missing: act=%0d pending exp=0", exp_q.size());
    end
    driving_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!driving_done) begin
      checks++; failures++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule